// File: doc/BRIEF.md
# Register Access Protection Checker

This block guards a register space against unwanted accesses. It holds a small bank of protection entries. Each entry describes one window of register addresses and says whether reads, writes or both are refused inside that window. Every access presented to the block is an 18-bit register address plus a direction flag. One cycle later the block reports whether the access is refused and, if it is, which entry caught it.

Software loads entries one at a time through a write port that takes a 32-bit packed word. The window size is always a power of two. The window start is the programmed address with its low bits cleared to the size alignment, and the block does this without reporting it. A window programmed at 0x07 with size 4 therefore guards 0x04..0x07, not 0x07..0x0A. An entry can refuse writes only, which leaves a region readable but not writable. All entries are compared in parallel. When several entries match, the lowest-numbered one is reported.

Top module: `prot_checker`

## Requirements
- R1: Reset clears every entry to the disabled state and forces `res_valid` and `res_block` low. After reset, no access is refused until an entry is loaded.
- R2: The packed entry word places the register address in bits 19:2, log2 of the window size in bits 28:24, the write-refuse flag in bit 29 and the read-refuse flag in bit 30. Bits 31, 23:20 and 1:0 have no effect.
- R3: An entry with size field n covers the 2^n addresses whose address bits above n-1 equal those of the programmed address, so the low n bits of the programmed address are ignored. A size field of 18 or more covers the whole 18-bit space.
- R4: An entry with bit 29 set refuses writes inside its window.
- R5: An entry with bit 30 set refuses reads inside its window. With both bits set, it refuses reads and writes. With bit 29 alone, reads pass.
- R6: An entry with neither bit 29 nor bit 30 set refuses nothing, whatever its window.
- R7: When an access is refused, `res_idx` gives the lowest-numbered entry that matches both the address and the direction. `res_idx` is 0 whenever `res_block` is low.
- R8: `res_valid` is high in exactly the cycle after an access with `acc_valid` high, and `res_block` can only be high together with `res_valid`.
- R9: An entry write is used by accesses from the next cycle on. An access in the same cycle as the write is judged against the entry's previous contents.
- R10: A write to an entry index of `N_ENTRIES` or above changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | $clog2(N_ENTRIES) (3) | Entry index to write |
| cfg_word | input | 32 | Packed entry word |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 18 | Register address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| res_valid | output | 1 | Verdict present for the previous cycle's access |
| res_block | output | 1 | The access is refused |
| res_idx | output | $clog2(N_ENTRIES) (3) | Lowest matching entry, 0 when not refused |

## Verification
Every verdict is due exactly one clock edge after its access is sampled. The bench drives each access on a falling edge and reads `res_valid`, `res_block` and `res_idx` on the next falling edge, before it drives the following access. An entry write also takes one edge. The bench therefore applies a write on one falling edge and issues accesses that should see it from the next falling edge on. The same-cycle case drives a write and an access together and expects the old verdict first, then the new one.

// File: rtl/prot_pkg.sv
package prot_pkg;

  // Address width fixed by the packed word layout (bits 19:2).
  localparam int ADDR_W   = 18;
  localparam int LG_W     = 5;
  localparam int WORD_W   = 32;
  localparam int RD_BIT   = 30;
  localparam int WR_BIT   = 29;
  localparam int LG_LSB   = 24;
  localparam int ADDR_LSB = 2;

  typedef struct packed {
    logic              rd_blk;
    logic              wr_blk;
    logic [LG_W-1:0]   lg;
    logic [ADDR_W-1:0] base;
  } prot_entry_t;

  // Mask keeping the address bits above the window size.
  function automatic logic [ADDR_W-1:0] window_mask(input logic [LG_W-1:0] lg);
    if (int'(lg) >= ADDR_W) return '0;
    return {ADDR_W{1'b1}} << lg;
  endfunction

  // Window start after the silent alignment.
  function automatic logic [ADDR_W-1:0] eff_base(input prot_entry_t e);
    return e.base & window_mask(e.lg);
  endfunction

  function automatic logic covers(input prot_entry_t e, input logic [ADDR_W-1:0] addr);
    return (addr & window_mask(e.lg)) == eff_base(e);
  endfunction

  function automatic logic dir_armed(input prot_entry_t e, input logic is_write);
    return is_write ? e.wr_blk : e.rd_blk;
  endfunction

endpackage

// File: rtl/prot_entry_bank.sv
module prot_entry_bank
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 6,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [WORD_W-1:0]             wr_word,
  output prot_entry_t [N_ENTRIES-1:0]   entries
);

  prot_entry_t dec_word;
  logic        idx_in_range;
  logic        unused_word_bits;

  assign dec_word.rd_blk = wr_word[RD_BIT];
  assign dec_word.wr_blk = wr_word[WR_BIT];
  assign dec_word.lg     = wr_word[LG_LSB +: LG_W];
  assign dec_word.base   = wr_word[ADDR_LSB +: ADDR_W];
  assign unused_word_bits = ^{wr_word[31], wr_word[23:20], wr_word[1:0]};
  assign idx_in_range    = int'(wr_idx) < N_ENTRIES;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && idx_in_range && (int'(wr_idx) == g);

    always_ff @(posedge clk) begin
      if (!rst_n)       entries[g] <= '0;
      else if (slot_we) entries[g] <= dec_word;
    end

    // R9
    slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) == g) |=>
        (entries[g].rd_blk == $past(wr_word[RD_BIT]) &&
         entries[g].wr_blk == $past(wr_word[WR_BIT]) &&
         entries[g].lg     == $past(wr_word[28:24]) &&
         entries[g].base   == $past(wr_word[19:2])));
  end

  // R10
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= N_ENTRIES) |=> $stable(entries));

endmodule

// File: rtl/prot_match.sv
module prot_match
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  prot_entry_t [N_ENTRIES-1:0] entries,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        is_write,
  output logic [N_ENTRIES-1:0]        win_hit,
  output logic [N_ENTRIES-1:0]        hit
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign win_hit[g] = covers(entries[g], addr);
    assign hit[g]     = win_hit[g] && dir_armed(entries[g], is_write);

    // R6
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!entries[g].rd_blk && !entries[g].wr_blk) |-> !hit[g]);

    // R3
    window_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> ((addr >> entries[g].lg) == (entries[g].base >> entries[g].lg)));
  end

endmodule

// File: rtl/prot_prio.sv
module prot_prio #(
  parameter int N_ENTRIES = 6,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] req,
  output logic [N_ENTRIES-1:0] grant,
  output logic [IDX_W-1:0]     idx,
  output logic                 any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any = |req;

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R7
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & (grant - 1'b1)) == '0) && (grant != '0));

endmodule

// File: rtl/prot_checker.sv
module prot_checker
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 6,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_word,
  input  logic              acc_valid,
  input  logic [17:0]       acc_addr,
  input  logic              acc_write,
  output logic              res_valid,
  output logic              res_block,
  output logic [IDX_W-1:0]  res_idx
);

  prot_entry_t [N_ENTRIES-1:0] entries;
  logic [N_ENTRIES-1:0]        win_hit;
  logic [N_ENTRIES-1:0]        dir_hit;
  logic [N_ENTRIES-1:0]        grant;
  logic [IDX_W-1:0]            first_idx;
  logic                        any_hit;
  logic                        refuse_now;
  logic                        unused_match;

  prot_entry_bank #(.N_ENTRIES(N_ENTRIES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_word (cfg_word),
    .entries (entries)
  );

  prot_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .entries  (entries),
    .addr     (acc_addr),
    .is_write (acc_write),
    .win_hit  (win_hit),
    .hit      (dir_hit)
  );

  prot_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (dir_hit),
    .grant (grant),
    .idx   (first_idx),
    .any   (any_hit)
  );

  assign unused_match = ^{win_hit, grant};
  assign refuse_now   = acc_valid && any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_block <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= acc_valid;
      res_block <= refuse_now;
      res_idx   <= refuse_now ? first_idx : '0;
    end
  end

  // R8
  verdict_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  // R8
  verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  // R8
  block_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_block |-> res_valid);

  // R7
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_block |-> (res_idx == '0));

endmodule

// File: tb/prot_checker_tb.sv
`timescale 1ns/1ps
module prot_checker_tb;

  localparam int N  = 6;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_word = '0;
  logic          acc_valid = 1'b0;
  logic [17:0]   acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          res_valid;
  logic          res_block;
  logic [IW-1:0] res_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mdl [N];

  always #4 clk = ~clk;

  prot_checker #(.N_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_word(cfg_word), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .res_valid(res_valid), .res_block(res_block),
    .res_idx(res_idx)
  );

  function automatic logic [31:0] mkw(bit rd, bit wr, int lg, int base);
    return (32'(rd) << 30) | (32'(wr) << 29) | (32'(lg & 31) << 24) | (32'(base & 18'h3FFFF) << 2);
  endfunction

  // Arithmetic model: window = floor(addr/len) equal to floor(base/len).
  function automatic void model(input int addr, input bit wr, output bit blk, output int idx);
    blk = 1'b0;
    idx = 0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [31:0] w;
      bit armed;
      w = mdl[i];
      armed = wr ? w[29] : w[30];
      if (armed) begin
        longint len;
        len = longint'(1) << w[28:24];
        if ((longint'(addr) / len) == (longint'(w[19:2]) / len)) begin
          blk = 1'b1;
          idx = i;
        end
      end
    end
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg(int idx, logic [31:0] word);
    cfg_we = 1'b1;
    cfg_idx = IW'(idx);
    cfg_word = word;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < N) mdl[idx] = word;
  endtask

  task automatic access(string tag, int addr, bit wr);
    bit blk;
    int idx;
    model(addr, wr, blk, idx);
    acc_valid = 1'b1;
    acc_addr = 18'(addr);
    acc_write = wr;
    @(negedge clk);
    check(tag, "valid", int'(res_valid), 1);
    check(tag, $sformatf("block a=%0h w=%0d", addr, wr), int'(res_block), int'(blk));
    check(tag, $sformatf("idx a=%0h w=%0d", addr, wr), int'(res_idx), idx);
  endtask

  task automatic sweep(string tag, int lo, int hi);
    for (int a = lo; a <= hi; a++) begin
      access(tag, a, 1'b0);
      access(tag, a, 1'b1);
    end
    acc_valid = 1'b0;
    @(negedge clk);
    check("R8", "valid idle", int'(res_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    acc_valid = 1'b0;
    cfg_we = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(res_valid), 0);
    check("R1", "block in reset", int'(res_block), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    @(negedge clk);
    do_reset();
    sweep("R1", 0, 31);

    // R2 R3 R5: both flags, base 0x07 size 4 -> 0x04..0x07
    cfg(0, mkw(1, 1, 2, 7));
    // R2 R4: write-only, junk bits set, size 8 at 0x20
    cfg(1, mkw(0, 1, 3, 32'h20) | 32'h80F0_0003);
    sweep("R2 R3 R4", 0, 47);

    // R5: read-refuse only, size 16 at 0x30
    cfg(2, mkw(1, 0, 4, 32'h33));
    // R6: no flags, wide window
    cfg(3, mkw(0, 0, 6, 0));
    sweep("R5 R6", 0, 79);

    // R7: overlapping full window on entry 5
    cfg(5, mkw(1, 1, 6, 32'h15));
    sweep("R7", 0, 79);

    // R10: out-of-range writes ignored
    cfg(6, mkw(1, 1, 31, 0));
    cfg(7, mkw(1, 1, 31, 0));
    sweep("R10", 128, 160);

    // R3: size field beyond address width covers everything
    cfg(4, mkw(1, 1, 31, 32'h3FFFF));
    sweep("R3", 32'h3FFF0, 32'h3FFFF);
    sweep("R3 R7", 0, 40);

    // R9: same-cycle write vs access
    cfg(4, 32'h0);
    acc_valid = 1'b1;
    acc_addr = 18'h200;
    acc_write = 1'b1;
    cfg_we = 1'b1;
    cfg_idx = IW'(4);
    cfg_word = mkw(1, 1, 4, 32'h200);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9", "old verdict", int'(res_block), 0);
    mdl[4] = mkw(1, 1, 4, 32'h200);
    access("R9", 32'h200, 1'b1);
    check("R9", "new idx", int'(res_idx), 4);
    sweep("R9", 32'h1FE, 32'h212);

    // R1: reset clears loaded entries
    do_reset();
    sweep("R1", 0, 79);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule